// File: doc/BRIEF.md
# Masked Vector Lane Extract Unit

This block copies one aligned 128-bit or 256-bit chunk out of a 256-bit or 512-bit integer source vector into the low part of a destination vector. An 8-bit immediate picks which chunk is copied. A per-element write mask then controls each 32-bit or 64-bit element of that chunk. Each masked-off element keeps its old destination value or becomes zero.

Two kinds of destination are supported. A register destination is written in full, and every bit above the extracted chunk is cleared. A memory destination is written only where elements are taken: the block emits per-dword write enables, and everything else keeps the old value. A separate unmasked legacy form always extracts 128 bits from a 256-bit source.

Encodings that break the reserved-field or length rules raise an illegal flag and leave the destination alone. The result is registered once and marked by a valid strobe.

Top module: `lx_extract_unit`

## Requirements
- R1: With a 256-bit source (`vlen_512`=0) and a 128-bit chunk (`chunk_256`=0), `imm[0]`=0 returns source bits 127:0 in destination bits 127:0, and `imm[0]`=1 returns source bits 255:128. Bits 7:1 of the immediate have no effect.
- R2: With a 512-bit source and a 128-bit chunk, `imm[1:0]`=k returns source bits 128k+127:128k in destination bits 127:0. Bits 7:2 of the immediate have no effect.
- R3: With a 512-bit source and a 256-bit chunk, `imm[0]` selects source bits 255:0 (0) or bits 511:256 (1) for destination bits 255:0. Bits 7:1 of the immediate have no effect.
- R4: When `mask_en`=1, `wmask[j]` governs element j of the chunk. With `elem_64`=0 an element is dword j; with `elem_64`=1 it is dwords 2j and 2j+1. Mask bits at or above the chunk's element count have no effect. When `mask_en`=0, every element of the chunk is taken from the source.
- R5: For a register destination (`to_mem`=0), a masked-off element keeps its `old_dst` value when `zero_mode`=0 and reads zero when `zero_mode`=1.
- R6: For a legal register destination, all destination bits above the chunk read zero and all 16 bits of `dword_we` are 1.
- R7: For a memory destination (`to_mem`=1), `zero_mode` has no effect and masked-off elements keep `old_dst`. All bits above the chunk keep `old_dst`. `dword_we[d]` is 1 exactly for the chunk dwords that were taken.
- R8: `illegal` is 1 when `xreg_field` is not 4'b1111, or when the legacy form is requested with `legacy_len`=0, or when a 256-bit chunk is requested with `vlen_512`=0. An illegal request returns `dst_out` equal to `old_dst` with `dword_we` all zero.
- R9: When `legacy_form`=1, the block behaves as a 128-bit chunk taken from a 256-bit source by `imm[0]` with masking disabled. In this form `vlen_512`, `chunk_256`, `elem_64`, `mask_en`, `zero_mode` and `wmask` have no effect.
- R10: `out_valid` is 1 in the cycle after an edge that samples `in_valid`=1 and is 0 otherwise, and `dst_out`, `dword_we` and `illegal` belong to that sampled request. An active-low synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Current destination contents |
| wmask | input | 8 | Per-element write mask |
| imm | input | 8 | Chunk-select immediate |
| vlen_512 | input | 1 | 1: 512-bit source, 0: 256-bit source |
| chunk_256 | input | 1 | 1: 256-bit chunk, 0: 128-bit chunk |
| elem_64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1: zero masked-off elements, 0: merge |
| to_mem | input | 1 | 1: memory destination, 0: register |
| legacy_form | input | 1 | Unmasked legacy 128-bit extract |
| legacy_len | input | 1 | Length bit of the legacy form |
| xreg_field | input | 4 | Reserved extra-register specifier |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 512 | New destination value |
| dword_we | output | 16 | Per-dword write enables |
| illegal | output | 1 | Illegal-request flag |

## Verification
The bench builds the block with its default 512-bit maximum width, 128-bit lanes and 8-bit mask. At these sizes a full sweep is practical. It covers every mask value and every low-order immediate, for each combination of source width, chunk size, element size, masking, zeroing and destination kind. That reaches every element boundary, every mask bit that falls outside the element count, and both halves and all four quarters of the source. Separate passes set the high immediate bits, run the legacy form with noisy mode inputs, hit each illegal encoding, and insert idle cycles between requests.

// File: rtl/lx_pkg.sv
// Package lx_pkg
// Shared sizes for the lane extract unit. Assumes dword (32-bit) granularity
// for all enables and that the chunk never exceeds two lanes.
package lx_pkg;
    localparam int DWORD_W  = 32;
    localparam int LANE_W   = 128;
    localparam int LANE_DW  = LANE_W / DWORD_W;
    localparam int CHUNK_DW = 2 * LANE_DW;
    localparam int CHUNK_W  = CHUNK_DW * DWORD_W;
endpackage

// File: rtl/lx_chunk_sel.sv
// Module lx_chunk_sel
// Picks one or two adjacent 128-bit lanes from the source vector.
// Assumes lane_idx is even whenever wide is set, so lane_idx+1 exists.
module lx_chunk_sel
    import lx_pkg::*;
#(
    parameter int MAX_VW = 512,
    localparam int NLANE = MAX_VW / LANE_W,
    localparam int LIDX_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic [MAX_VW-1:0]  src_vec,
    input  logic [LIDX_W-1:0]  lane_idx,
    input  logic               wide,
    output logic [CHUNK_W-1:0] chunk
);
    logic [LANE_W-1:0] lanes [NLANE];

    // Split the source into lanes.
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign lanes[k] = src_vec[k*LANE_W +: LANE_W];
    end

    // Mux the low lane and, for wide chunks, the lane above it.
    always_comb begin
        chunk = '0;
        for (int k = 0; k < NLANE; k++) begin
            if (LIDX_W'(k) == lane_idx) begin
                chunk[LANE_W-1:0] = lanes[k];
            end
            if (wide && (LIDX_W'(k) == (lane_idx | LIDX_W'(1)))) begin
                chunk[CHUNK_W-1:LANE_W] = lanes[k];
            end
        end
    end
endmodule

// File: rtl/lx_elem_mask.sv
// Module lx_elem_mask
// Expands the element write mask into per-dword take and in-chunk flags.
// Assumes an 8-bit mask is enough for the largest element count (8 dwords).
module lx_elem_mask
    import lx_pkg::*;
#(
    parameter int MASK_W = 8
) (
    input  logic [MASK_W-1:0]   wmask,
    input  logic                mask_en,
    input  logic                elem_64,
    input  logic                wide,
    output logic [CHUNK_DW-1:0] in_chunk,
    output logic [CHUNK_DW-1:0] take
);
    for (genvar d = 0; d < CHUNK_DW; d++) begin : g_dw
        logic mbit;
        // Choose the mask bit that owns this dword for the element size.
        always_comb begin
            mbit = elem_64 ? wmask[d/2] : wmask[d];
        end
        // Dword lies inside the chunk and is taken from the source or not.
        always_comb begin
            in_chunk[d] = (d < LANE_DW) || wide;
            take[d]     = in_chunk[d] && (!mask_en || mbit);
        end
    end
endmodule

// File: rtl/lx_merge.sv
// Module lx_merge
// Builds the new destination and per-dword write enables from the chunk.
// Assumes dwords at or above CHUNK_DW are never part of the chunk.
module lx_merge
    import lx_pkg::*;
#(
    parameter int MAX_VW = 512,
    localparam int NDW = MAX_VW / DWORD_W
) (
    input  logic [CHUNK_W-1:0]  chunk,
    input  logic [MAX_VW-1:0]   old_dst,
    input  logic [CHUNK_DW-1:0] in_chunk,
    input  logic [CHUNK_DW-1:0] take,
    input  logic                zero_mode,
    input  logic                to_mem,
    output logic [MAX_VW-1:0]   new_dst,
    output logic [NDW-1:0]      we
);
    for (genvar d = 0; d < NDW; d++) begin : g_dw
        logic [DWORD_W-1:0] old_w;
        assign old_w = old_dst[d*DWORD_W +: DWORD_W];
        if (d < CHUNK_DW) begin : g_in
            // Chunk dword: source, old value or zero.
            always_comb begin
                if (take[d]) begin
                    new_dst[d*DWORD_W +: DWORD_W] = chunk[d*DWORD_W +: DWORD_W];
                end else if (in_chunk[d] && !to_mem && zero_mode) begin
                    new_dst[d*DWORD_W +: DWORD_W] = '0;
                end else if (in_chunk[d] || to_mem) begin
                    new_dst[d*DWORD_W +: DWORD_W] = old_w;
                end else begin
                    new_dst[d*DWORD_W +: DWORD_W] = '0;
                end
                we[d] = to_mem ? take[d] : 1'b1;
            end
        end else begin : g_up
            // Dword above any chunk: cleared in a register, kept in memory.
            always_comb begin
                new_dst[d*DWORD_W +: DWORD_W] = to_mem ? old_w : '0;
                we[d] = !to_mem;
            end
        end
    end
endmodule

// File: rtl/lx_legal.sv
// Module lx_legal
// Flags encodings that must not update the destination.
// Assumes the reserved specifier must read all ones.
module lx_legal (
    input  logic [3:0] xreg_field,
    input  logic       legacy_form,
    input  logic       legacy_len,
    input  logic       wide,
    input  logic       vlen_512,
    output logic       illegal
);
    // Combine the three rejection rules.
    always_comb begin
        illegal = (xreg_field != 4'b1111)
               || (legacy_form && !legacy_len)
               || (wide && !vlen_512);
    end
endmodule

// File: rtl/lx_extract_unit.sv
// Module lx_extract_unit
// Masked chunk extract with one register stage. Assumes a 512-bit maximum
// vector width by default, 128-bit lanes and an 8-bit element mask.
module lx_extract_unit
    import lx_pkg::*;
#(
    parameter int MAX_VW = 512,
    parameter int MASK_W = 8,
    localparam int NDW = MAX_VW / DWORD_W,
    localparam int NLANE = MAX_VW / LANE_W,
    localparam int LIDX_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAX_VW-1:0] src_vec,
    input  logic [MAX_VW-1:0] old_dst,
    input  logic [MASK_W-1:0] wmask,
    input  logic [7:0]        imm,
    input  logic              vlen_512,
    input  logic              chunk_256,
    input  logic              elem_64,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              to_mem,
    input  logic              legacy_form,
    input  logic              legacy_len,
    input  logic [3:0]        xreg_field,
    output logic              out_valid,
    output logic [MAX_VW-1:0] dst_out,
    output logic [NDW-1:0]    dword_we,
    output logic              illegal
);
    logic                eff_vlen, eff_wide, eff_mask_en;
    logic [LIDX_W-1:0]   lane_idx;
    logic [CHUNK_W-1:0]  chunk;
    logic [CHUNK_DW-1:0] in_chunk, take;
    logic [MAX_VW-1:0]   new_dst;
    logic [NDW-1:0]      we;
    logic                bad;
    logic                unused_imm_hi;

    assign unused_imm_hi = ^imm[7:2];

    // Legacy form overrides the mode inputs.
    always_comb begin
        eff_vlen    = legacy_form ? 1'b0 : vlen_512;
        eff_wide    = legacy_form ? 1'b0 : chunk_256;
        eff_mask_en = legacy_form ? 1'b0 : mask_en;
    end

    // Lane index from the immediate for the chunk size and source width.
    always_comb begin
        if (eff_wide) begin
            lane_idx = LIDX_W'({imm[0], 1'b0});
        end else if (eff_vlen) begin
            lane_idx = LIDX_W'(imm[1:0]);
        end else begin
            lane_idx = LIDX_W'(imm[0]);
        end
    end

    lx_chunk_sel #(.MAX_VW(MAX_VW)) u_sel (
        .src_vec (src_vec),
        .lane_idx(lane_idx),
        .wide    (eff_wide),
        .chunk   (chunk)
    );

    lx_elem_mask #(.MASK_W(MASK_W)) u_mask (
        .wmask   (wmask),
        .mask_en (eff_mask_en),
        .elem_64 (elem_64),
        .wide    (eff_wide),
        .in_chunk(in_chunk),
        .take    (take)
    );

    lx_merge #(.MAX_VW(MAX_VW)) u_merge (
        .chunk    (chunk),
        .old_dst  (old_dst),
        .in_chunk (in_chunk),
        .take     (take),
        .zero_mode(zero_mode),
        .to_mem   (to_mem),
        .new_dst  (new_dst),
        .we       (we)
    );

    lx_legal u_legal (
        .xreg_field (xreg_field),
        .legacy_form(legacy_form),
        .legacy_len (legacy_len),
        .wide       (eff_wide),
        .vlen_512   (eff_vlen),
        .illegal    (bad)
    );

    // Result register with valid; illegal requests pass old_dst unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
            dword_we  <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_out  <= bad ? old_dst : new_dst;
                dword_we <= bad ? '0 : we;
                illegal  <= bad;
            end
        end
    end
endmodule

// File: rtl/lx_extract_sva.sv
// Module lx_extract_sva
// Port-level checks for lx_extract_unit, attached by bind below.
module lx_extract_sva
    import lx_pkg::*;
#(
    parameter int MAX_VW = 512,
    parameter int MASK_W = 8,
    localparam int NDW = MAX_VW / DWORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MAX_VW-1:0] src_vec,
    input logic [MAX_VW-1:0] old_dst,
    input logic [MASK_W-1:0] wmask,
    input logic [7:0]        imm,
    input logic              vlen_512,
    input logic              chunk_256,
    input logic              elem_64,
    input logic              mask_en,
    input logic              zero_mode,
    input logic              to_mem,
    input logic              legacy_form,
    input logic              legacy_len,
    input logic [3:0]        xreg_field,
    input logic              out_valid,
    input logic [MAX_VW-1:0] dst_out,
    input logic [NDW-1:0]    dword_we,
    input logic              illegal
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_BAD_SPEC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xreg_field != 4'b1111) |=> illegal); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xreg_field != 4'b1111) |=> (dword_we == '0 && dst_out == $past(old_dst))); // R8
    AST_REG_WE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && !$past(to_mem)) |-> (&dword_we)); // R6
    AST_REG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && !$past(to_mem)) |-> (dst_out[MAX_VW-1:CHUNK_W] == '0)); // R6
    AST_MEM_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(to_mem)) |-> (dword_we[NDW-1:CHUNK_DW] == '0
            && dst_out[MAX_VW-1:CHUNK_W] == $past(old_dst[MAX_VW-1:CHUNK_W]))); // R7
endmodule

bind lx_extract_unit lx_extract_sva #(.MAX_VW(MAX_VW), .MASK_W(MASK_W)) u_sva (.*);

// File: tb/tb_lx_extract_unit.sv
module tb_lx_extract_unit;
    localparam int VW = 512;
    localparam int NDW = VW / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0, old_dst = '0;
    logic [7:0] wmask = '0, imm = '0;
    logic vlen_512 = 0, chunk_256 = 0, elem_64 = 0, mask_en = 0, zero_mode = 0;
    logic to_mem = 0, legacy_form = 0, legacy_len = 1;
    logic [3:0] xreg_field = 4'hF;
    logic out_valid, illegal;
    logic [VW-1:0] dst_out;
    logic [NDW-1:0] dword_we;

    int n_cmp = 0, n_bad = 0, seq = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lx_extract_unit dut (.*);

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected result computed from the requirements.
    task automatic model(output logic [VW-1:0] e_dst, output logic [NDW-1:0] e_we,
                         output logic e_ill);
        logic v512, wide, men;
        int ndw, base;
        v512 = legacy_form ? 1'b0 : vlen_512;
        wide = legacy_form ? 1'b0 : chunk_256;
        men  = legacy_form ? 1'b0 : mask_en;
        e_ill = (xreg_field != 4'hF) || (legacy_form && !legacy_len) || (wide && !v512);
        ndw = wide ? 8 : 4;
        if (wide) base = imm[0] * 8;
        else if (v512) base = imm[1:0] * 4;
        else base = imm[0] * 4;
        for (int d = 0; d < NDW; d++) begin
            logic mb;
            logic [31:0] o;
            o = old_dst[d*32 +: 32];
            mb = elem_64 ? wmask[d/2] : wmask[d % 8];
            if (e_ill) begin
                e_dst[d*32 +: 32] = o; e_we[d] = 0;
            end else if (d >= ndw) begin
                e_dst[d*32 +: 32] = to_mem ? o : 32'h0; e_we[d] = !to_mem;
            end else if (!men || mb) begin
                e_dst[d*32 +: 32] = src_vec[(base+d)*32 +: 32]; e_we[d] = 1;
            end else begin
                e_dst[d*32 +: 32] = (!to_mem && zero_mode) ? 32'h0 : o;
                e_we[d] = !to_mem;
            end
        end
    endtask

    task automatic fill();
        seq++;
        for (int d = 0; d < NDW; d++) begin
            src_vec[d*32 +: 32] = 32'h5A00_0000 ^ (d * 32'h0101_0101) ^ (seq * 7) | 32'h1;
            old_dst[d*32 +: 32] = 32'hC300_0000 ^ (d * 32'h0011_0000) ^ (seq * 13) | 32'h2;
        end
    endtask

    // Drive one request at negedge, check it one cycle later.
    task automatic run(input string req);
        logic [VW-1:0] e_dst;
        logic [NDW-1:0] e_we;
        logic e_ill;
        fill();
        in_valid = 1;
        model(e_dst, e_we, e_ill);
        @(posedge clk);
        @(negedge clk);
        chk({req, " valid"}, VW'(out_valid), VW'(1));
        chk({req, " illegal"}, VW'(illegal), VW'(e_ill));
        chk({req, " dst"}, dst_out, e_dst);
        chk({req, " we"}, VW'(dword_we), VW'(e_we));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", VW'(out_valid), VW'(0));
        rst_n = 1;
        @(negedge clk);
        chk("R10 idle valid", VW'(out_valid), VW'(0));
        // Main sweep: R1 R2 R3 R4 R5 R6 R7 (and R8 for wide on 256-bit source).
        for (int cfg = 0; cfg < 64; cfg++) begin
            for (int im = 0; im < 4; im++) begin
                for (int m = 0; m < 256; m++) begin
                    {vlen_512, chunk_256, elem_64, mask_en, zero_mode, to_mem} = 6'(cfg);
                    imm = 8'(im); wmask = 8'(m);
                    if (!mask_en && m > 3) continue;
                    run("R1/R2/R3/R4/R5/R6/R7");
                end
            end
        end
        // High immediate bits ignored: R1 R2 R3.
        for (int im = 0; im < 256; im += 5) begin
            {vlen_512, chunk_256, elem_64, mask_en, zero_mode, to_mem} = 6'b110100;
            imm = 8'(im); wmask = 8'h5C;
            run("R3 imm-high");
            vlen_512 = 1; chunk_256 = 0; run("R2 imm-high");
            vlen_512 = 0; run("R1 imm-high");
        end
        // Legacy form: R9, and its illegal length bit for R8.
        legacy_form = 1;
        for (int k = 0; k < 64; k++) begin
            {vlen_512, chunk_256, elem_64, mask_en, zero_mode, to_mem} = 6'(k);
            imm = 8'(k * 3); wmask = 8'(k * 37); legacy_len = 1;
            run("R9 legacy");
            legacy_len = 0;
            run("R8 legacy-len");
        end
        legacy_form = 0; legacy_len = 1;
        // Reserved field: R8.
        for (int x = 0; x < 15; x++) begin
            xreg_field = 4'(x); vlen_512 = 1; chunk_256 = x[0]; to_mem = x[1];
            mask_en = 1; wmask = 8'hA5; imm = 8'(x);
            run("R8 xreg");
        end
        xreg_field = 4'hF;
        // Idle gaps: R10.
        in_valid = 0;
        @(posedge clk); @(negedge clk);
        chk("R10 gap valid", VW'(out_valid), VW'(0));
        run("R10 after gap");
        in_valid = 0;
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        chk("R10 reset clears", VW'(out_valid), VW'(0));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule